// File: doc/BRIEF.md
# I2C Addressed Target with Clock Stretching

This block is a two-wire serial bus target that answers one 7-bit address, set on an input pin. It takes SCL and SDA samples that are already synchronised to the system clock and oversampled several times per bit. It drives two open-drain enables, one per line; an enable at 1 pulls that line low. When the master writes, each received byte is offered to the local side over a valid/ready port and then acknowledged. When the master reads, each byte to send is requested over a second valid/ready port.

Whenever the local side has not yet taken a received byte, or has not yet supplied the next byte to send, the block holds SCL low, so the master waits instead of losing data. A master NACK after a read byte ends the read and returns the block to idle. A start condition, including a repeated start, always restarts address reception. A stop condition always ends the transaction.

Top module: `i2c_target`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, rx_valid_o and tx_ready_o are all 0.
- R2: A start condition (SDA falls while SCL is high) begins address reception from any state, and any partly received byte is dropped. A stop condition (SDA rises while SCL is high) returns the block to idle. In both cases both line enables are 0 on the next clock.
- R3: The first eight bits after a start are sampled on SCL rising edges, most significant bit first. They form a 7-bit address followed by a direction bit, where 0 means the master writes and 1 means the master reads. If the address equals own_addr_i, the block holds SDA low through the high phase of the ninth clock (ACK).
- R4: If the address does not match, the block pulls neither line low and makes no local handshake until the next start or stop.
- R5: In the write direction, each data byte is assembled most significant bit first and presented on rx_data_o with rx_valid_o. rx_data_o stays unchanged while rx_valid_o is 1 and rx_ready_i is 0.
- R6: After the falling edge of the eighth SCL clock of a received byte, SCL is held low until the rx handshake completes. The block then drives ACK for the ninth clock.
- R7: In the read direction, after an acknowledged address or a master ACK, tx_ready_o is raised and SCL is held low until tx_valid_i is 1. The byte is then sent most significant bit first, one bit per SCL low phase.
- R8: The master's ninth bit after a sent byte decides what follows. SDA low (ACK) requests the next byte. SDA high (NACK) returns the block to idle, with SDA released and tx_ready_o kept low until a new addressed read.
- R9: sda_oe_o changes only while SCL is low. A hold on SCL begins only while SCL is already low. When a hold ends, the new SDA level has been set at least one clock before SCL is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | Address this target answers |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte is waiting |
| rx_ready_i | input | 1 | Local side takes the received byte |
| tx_data_i | input | 8 | Byte to send to the master |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Target requests a byte to send |

## Verification
Two events can land in the same cycle: the local handshake that ends a clock stretch, and the change of SDA to the acknowledge or first data level. If both took effect together, SDA would change as SCL rises. The bench varies the local response delay from zero upward, so that some handshakes complete in the very first stretch cycle. It judges the result by watching every edge of sda_oe_o against the bus SCL level and against the release of scl_oe_o. A second overlap, a repeated start or a stop arriving partway through a byte, is provoked by breaking off a byte after a few bits. The bench then checks that no partial byte reaches the local port and that the next addressed transfer is correct.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_HOLD,
    ST_RX_ACK,
    ST_TX_LOAD,
    ST_TX,
    ST_TX_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  // idle bus reads high on both lines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_shreg.sv
module i2c_tgt_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] sh_q_i,
  output logic              sh_shift_o,
  output logic              sh_load_o,
  input  logic              rx_ready_i,
  input  logic              tx_valid_i,
  output logic              rx_valid_o,
  output logic              tx_ready_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  tgt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rw_q, rw_d;
  logic             hold_q, hold_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    rw_d       = rw_q;
    hold_d     = 1'b0;
    sh_shift_o = 1'b0;
    sh_load_o  = 1'b0;
    if (stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i && cnt_q != CNT_FULL) begin
            sh_shift_o = 1'b1;
            cnt_d      = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            if (state_q == ST_RX) begin
              state_d = ST_RX_HOLD;
            end else if (sh_q_i[BYTE_W-1 -: ADDR_W] == own_addr_i) begin
              state_d = ST_ADDR_ACK;
              rw_d    = sh_q_i[0];
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall_i) begin
            cnt_d   = '0;
            state_d = (state_q == ST_ADDR_ACK && rw_q) ? ST_TX_LOAD : ST_RX;
          end
        end
        ST_RX_HOLD: begin
          if (rx_ready_i) begin
            state_d = ST_RX_ACK;
            hold_d  = 1'b1;
          end
        end
        ST_TX_LOAD: begin
          if (tx_valid_i) begin
            sh_load_o = 1'b1;
            state_d   = ST_TX;
            cnt_d     = '0;
            hold_d    = 1'b1;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d = ST_TX_MACK;
            end else begin
              sh_shift_o = 1'b1;
              cnt_d      = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_MACK: begin
          if (scl_rise_i && sda_i) state_d = ST_IDLE;
          else if (scl_fall_i)     state_d = ST_TX_LOAD;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rw_q    <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rw_q    <= rw_d;
      hold_q  <= hold_d;
    end
  end

  // hold_q keeps SCL low one extra clock so SDA settles before release
  assign scl_oe_o   = (state_q == ST_RX_HOLD) | (state_q == ST_TX_LOAD) | hold_q;
  assign sda_oe_o   = (state_q == ST_ADDR_ACK) | (state_q == ST_RX_ACK) |
                      ((state_q == ST_TX) & ~sh_q_i[BYTE_W-1]);
  assign rx_valid_o = (state_q == ST_RX_HOLD);
  assign tx_ready_o = (state_q == ST_TX_LOAD);
endmodule

// File: rtl/i2c_target.sv
module i2c_target
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  logic              scl_rise, scl_fall, start, stop;
  logic              sh_shift, sh_load;
  logic [BYTE_W-1:0] sh_q;

  i2c_tgt_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_tgt_shreg #(.W(BYTE_W)) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (sh_shift),
    .bit_i      (sda_i),
    .load_i     (sh_load),
    .load_val_i (tx_data_i),
    .q_o        (sh_q)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_addr_i (own_addr_i),
    .sda_i      (sda_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sh_q_i     (sh_q),
    .sh_shift_o (sh_shift),
    .sh_load_o  (sh_load),
    .rx_ready_i (rx_ready_i),
    .tx_valid_i (tx_valid_i),
    .rx_valid_o (rx_valid_o),
    .tx_ready_o (tx_ready_o),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  assign rx_data_o = sh_q;
endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk
  import i2c_tgt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_i,
  input logic              scl_oe_o,
  input logic              sda_oe_o,
  input logic [BYTE_W-1:0] rx_data_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R9
  sda_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  // R9
  stretch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    $rose(scl_oe_o) |-> !$past(scl_i));

  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

  // R2
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=>
      (!sda_oe_o && !scl_oe_o && !rx_valid_o && !tx_ready_o));

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=>
      (!sda_oe_o && !scl_oe_o && !rx_valid_o && !tx_ready_o));

  // R7
  tx_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed_q)
    (tx_ready_o && tx_valid_i) |=> !tx_ready_o);
endmodule

bind i2c_target i2c_target_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o)
);

// File: tb/i2c_target_bench.sv
module i2c_target_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic       scl_oe, sda_oe;
  logic       scl_bus, sda_bus;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0, tx_ready;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] rx_log [512];
  int rx_n = 0, rx_wait = 0, tx_n = 0, tx_wait = 0;
  int run = 0, run_max = 0, sda_hi_chg = 0, early_rel = 0;
  logic sda_oe_prev = 1'b0, scl_oe_prev = 1'b0, drv_seen = 1'b0;

  always #5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_target u_i2c_target (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .own_addr_i (own_addr),
    .scl_i      (scl_bus),
    .sda_i      (sda_bus),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .rx_ready_i (rx_ready),
    .tx_data_i  (tx_data),
    .tx_valid_i (tx_valid),
    .tx_ready_o (tx_ready)
  );

  function automatic logic [7:0] tx_val(int n);
    return 8'((n * 53 + 3) & 255);
  endfunction

  // local receive side: delay varies with byte index
  always @(negedge clk) begin
    if (rx_ready) rx_ready = 1'b0;
    else if (rx_valid) begin
      if (rx_wait >= (rx_n % 5) * 4) begin
        rx_ready = 1'b1;
        rx_log[rx_n % 512] = rx_data;
        rx_n++;
        rx_wait = 0;
      end else rx_wait++;
    end
  end

  // local transmit side
  always @(negedge clk) begin
    if (tx_valid) tx_valid = 1'b0;
    else if (tx_ready) begin
      if (tx_wait >= (tx_n % 4) * 5) begin
        tx_valid = 1'b1;
        tx_data  = tx_val(tx_n);
        tx_n++;
        tx_wait = 0;
      end else tx_wait++;
    end
  end

  // line monitors
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sda_oe != sda_oe_prev && scl_bus) sda_hi_chg++;
      if (scl_oe_prev && !scl_oe && sda_oe != sda_oe_prev) early_rel++;
      if (sda_oe) drv_seen = 1'b1;
      if (scl_oe) run++;
      else begin
        if (run > run_max) run_max = run;
        run = 0;
      end
    end
    sda_oe_prev = sda_oe;
    scl_oe_prev = scl_oe;
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; wait_cyc(2);
    m_scl = 1'b1; wait_high(); wait_cyc(2);
    m_sda = 1'b0; wait_cyc(2);
    m_scl = 1'b0; wait_cyc(2);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wait_cyc(2);
    m_scl = 1'b1; wait_high(); wait_cyc(2);
    m_sda = 1'b1; wait_cyc(3);
  endtask

  task automatic bit_out(logic b);
    m_sda = b; wait_cyc(2);
    m_scl = 1'b1; wait_high(); wait_cyc(2);
    m_scl = 1'b0; wait_cyc(2);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wait_cyc(2);
    m_scl = 1'b1; wait_high(); wait_cyc(1);
    b = sda_bus; wait_cyc(1);
    m_scl = 1'b0; wait_cyc(2);
  endtask

  task automatic byte_out(logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic byte_in(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(nack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int base;
    wait_cyc(3);
    check_eq("R1 scl_oe", int'(scl_oe), 0);
    check_eq("R1 sda_oe", int'(sda_oe), 0);
    rst_ni = 1'b1;
    wait_cyc(3);
    check_eq("R1 rx_valid", int'(rx_valid), 0);
    check_eq("R1 tx_ready", int'(tx_ready), 0);

    // R3 R4: sweep every address with a data byte
    for (int a = 0; a < 128; a++) begin
      base = rx_n;
      drv_seen = 1'b0;
      m_start();
      byte_out({7'(a), 1'b0}, ack);
      check_eq((a == int'(own_addr)) ? "R3 addr ack" : "R4 addr nack", int'(ack),
               int'(a == int'(own_addr)));
      byte_out(8'(a * 3 + 1), ack);
      m_stop();
      if (a == int'(own_addr)) begin
        check_eq("R5 sweep byte", int'(rx_log[base % 512]), (a * 3 + 1) & 255);
      end else begin
        check_eq("R4 no drive", int'(drv_seen), 0);
        check_eq("R4 no handshake", rx_n - base, 0);
      end
    end

    // R5 R6: all byte values in one write with varied local delay
    base = rx_n;
    run_max = 0;
    m_start();
    byte_out({own_addr, 1'b0}, ack);
    check_eq("R3 write ack", int'(ack), 1);
    for (int k = 0; k < 256; k++) begin
      byte_out(8'((k * 29 + 7) & 255), ack);
      check_eq("R6 data ack", int'(ack), 1);
    end
    m_stop();
    check_eq("R5 byte count", rx_n - base, 256);
    for (int k = 0; k < 256; k++)
      check_eq("R5 byte value", int'(rx_log[(base + k) % 512]), (k * 29 + 7) & 255);
    check_eq("R6 stretch seen", int'(run_max >= 16), 1);
    check_eq("R2 released after stop", int'(scl_oe | sda_oe), 0);

    // R7 R8: read 16 bytes, NACK the last
    base = tx_n;
    run_max = 0;
    m_start();
    byte_out({own_addr, 1'b1}, ack);
    check_eq("R3 read ack", int'(ack), 1);
    for (int j = 0; j < 16; j++) begin
      byte_in(v, j == 15);
      check_eq("R7 read byte", int'(v), int'(tx_val(base + j)));
    end
    wait_cyc(12);
    check_eq("R8 no request after nack", int'(tx_ready), 0);
    check_eq("R8 sda released after nack", int'(sda_oe), 0);
    check_eq("R8 byte count", tx_n - base, 16);
    check_eq("R7 stretch seen", int'(run_max >= 15), 1);
    m_stop();

    // R2: repeated start mid-byte, then a read
    base = rx_n;
    m_start();
    byte_out({own_addr, 1'b0}, ack);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    m_start();
    check_eq("R2 partial byte dropped", rx_n - base, 0);
    byte_out({own_addr, 1'b1}, ack);
    check_eq("R2 readdress ack", int'(ack), 1);
    byte_in(v, 1'b1);
    check_eq("R2 read after restart", int'(v), int'(tx_val(tx_n - 1)));
    m_stop();

    // R2: stop mid-byte
    m_start();
    byte_out({own_addr, 1'b0}, ack);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    m_stop();
    wait_cyc(2);
    check_eq("R2 stop mid byte", rx_n - base, 0);
    check_eq("R2 idle lines", int'(scl_oe | sda_oe | rx_valid | tx_ready), 0);

    // R3: another own address; the old one is ignored
    own_addr = 7'h51;
    m_start();
    byte_out({7'h2A, 1'b0}, ack);
    check_eq("R4 old address", int'(ack), 0);
    m_stop();
    base = rx_n;
    m_start();
    byte_out({7'h51, 1'b0}, ack);
    check_eq("R3 new address", int'(ack), 1);
    byte_out(8'hC3, ack);
    m_stop();
    check_eq("R5 new address byte", int'(rx_log[base % 512]), 8'hC3);

    check_eq("R9 sda change with scl high", sda_hi_chg, 0);
    check_eq("R9 sda set before release", early_rel, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule